// File: doc/BRIEF.md
# Dual-Width ALU with Branch-Condition Evaluator

This block is the combinational execute stage of a small 16-bit processor. From an 8-bit opcode it picks one of ten operations: add, subtract, AND, OR, XOR, shift left, arithmetic shift right, logical shift right, unsigned divide and unsigned multiply. Each operation can run on a byte or on a full word. The results appear in the same cycle on two result buses, together with a 4-bit flag vector. Divide and multiply fill both result buses. The other operations use only the primary bus and leave the secondary bus at zero.

A separate evaluator, inside the same top module, takes a stored flag vector and a jump opcode and reports whether the jump is taken. The surrounding core owns the register file, stores the flags and delivers traps. When a divisor is zero, this block only raises a fault line.

Top module: `alu_branch_unit`

## Requirements
- R1: The byte form of each operation sits on an odd opcode and the word form on the next even opcode. In order: add 0x41, subtract 0x43, AND 0x45, OR 0x47, XOR 0x49, shift left 0x4B, arithmetic shift right 0x4D, logical shift right 0x4F, divide 0x51, multiply 0x53. Byte forms read only bits 7:0 of each operand, and their results are zero-extended to 16 bits. An opcode outside 0x41 to 0x54 gives zero on both results, zero flags and no fault.
- R2: Add and subtract return their result modulo the operation width. The carry flag holds the carry out for add and the borrow for subtract.
- R3: The overflow flag of add and subtract is set exactly when the signed two's-complement result does not fit the operation width.
- R4: AND, OR and XOR return the bitwise result and clear carry and overflow.
- R5: Each shift takes its amount from the whole second operand at the operation width. Logical right and left shifts fill with zeros, and the arithmetic right shift replicates the sign bit. An amount equal to or greater than the width gives zero for the left and logical right shifts, and all sign bits for the arithmetic shift. Shifts clear carry and overflow.
- R6: Divide places the unsigned quotient on the primary result and the remainder on the secondary result.
- R7: div_fault_o rises when a divide opcode meets a divisor that is zero at the operation width; the results are then undefined. For every other case it stays low.
- R8: Multiply places the low half of the double-width unsigned product on the primary result and the high half on the secondary result.
- R9: The flag vector uses bit 0 for zero, set when the primary result is zero at the operation width; bit 1 for sign, a copy of the top bit of the primary result at that width; bit 2 for carry; and bit 3 for overflow. Divide and multiply clear carry and overflow.
- R10: The evaluator takes jumps on these conditions. Zero, overflow and carry each have a set/clear pair: 0x2F zero set, 0x34 zero clear, 0x35 overflow set, 0x36 overflow clear, 0x37 carry set, 0x38 carry clear. Signed comparisons: 0x30 sign differs from overflow; 0x33 sign equals overflow; 0x32 sign equals overflow and zero clear. Unsigned comparisons: 0x39 carry and zero both clear; 0x3A carry or zero set. Any other opcode is not taken.
- R11: Opcode 0x31 is taken when sign differs from overflow or zero is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 8 | Operation opcode |
| a_i | input | 16 | First operand (dividend, minuend, shifted value) |
| b_i | input | 16 | Second operand (divisor, subtrahend, shift amount) |
| res_lo_o | output | 16 | Primary result: sum, quotient or low product half |
| res_hi_o | output | 16 | Secondary result: remainder or high product half |
| flags_o | output | 4 | Flags {overflow, carry, sign, zero} |
| div_fault_o | output | 1 | Divide by zero detected |
| br_op_i | input | 8 | Jump opcode to evaluate |
| br_flags_i | input | 4 | Stored flags, same layout as flags_o |
| br_taken_o | output | 1 | Jump condition holds |

## Verification
The bench builds the block with its default data width of 16. This yields an 8-bit byte lane and a 16-bit word lane, so every operation is exercised at both widths. At both widths the bench drives the shift limit exactly at 8 and 16 and beyond them. A byte shift amount whose upper operand byte is nonzero shows that the byte lane ignores those bits. A byte divisor that is zero only in its low byte shows the same for the fault. The evaluator is swept over all sixteen flag combinations for each jump opcode, and also at the two opcodes that border the jump range.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [3:0] {
        FN_ADD = 4'd0,
        FN_SUB = 4'd1,
        FN_AND = 4'd2,
        FN_OR  = 4'd3,
        FN_XOR = 4'd4,
        FN_SHL = 4'd5,
        FN_ASR = 4'd6,
        FN_LSR = 4'd7,
        FN_DIV = 4'd8,
        FN_MUL = 4'd9
    } alu_fn_e;

    // bit 3 overflow, bit 2 carry, bit 1 sign, bit 0 zero
    typedef struct packed {
        logic v;
        logic c;
        logic s;
        logic z;
    } flags_t;

    localparam logic [7:0] OP_ALU_FIRST = 8'h41;
    localparam logic [7:0] OP_ALU_LAST  = 8'h54;

    localparam logic [7:0] BR_ZS   = 8'h2F;
    localparam logic [7:0] BR_SLT  = 8'h30;
    localparam logic [7:0] BR_SLE  = 8'h31;
    localparam logic [7:0] BR_SGT  = 8'h32;
    localparam logic [7:0] BR_SGE  = 8'h33;
    localparam logic [7:0] BR_ZC   = 8'h34;
    localparam logic [7:0] BR_VS   = 8'h35;
    localparam logic [7:0] BR_VC   = 8'h36;
    localparam logic [7:0] BR_CS   = 8'h37;
    localparam logic [7:0] BR_CC   = 8'h38;
    localparam logic [7:0] BR_UGT  = 8'h39;
    localparam logic [7:0] BR_ULE  = 8'h3A;

endpackage

// File: rtl/alu_lane.sv
module alu_lane
    import alu_pkg::*;
#(
    parameter int LW = 16
) (
    input  alu_fn_e         fn_i,
    input  logic [LW-1:0]   a_i,
    input  logic [LW-1:0]   b_i,
    output logic [LW-1:0]   lo_o,
    output logic [LW-1:0]   hi_o,
    output flags_t          flags_o,
    output logic            dz_o
);

    localparam int SHW = $clog2(LW);
    localparam logic [LW-1:0] SH_LIMIT = LW'(LW);
    localparam int MSB = LW - 1;

    typedef struct packed {
        logic [LW-1:0] lo;
        logic [LW-1:0] hi;
        flags_t        fl;
        logic          dz;
    } lane_out_t;

    lane_out_t       lane_d;
    logic [LW:0]     sum_w;
    logic [LW:0]     diff_w;
    logic [2*LW-1:0] prod_w;
    logic            sh_over;
    logic [SHW-1:0]  sh_amt;
    logic            cin_add;
    logic            cin_sub;

    always_comb begin
        sum_w   = {1'b0, a_i} + {1'b0, b_i};
        diff_w  = {1'b0, a_i} - {1'b0, b_i};
        prod_w  = {{LW{1'b0}}, a_i} * {{LW{1'b0}}, b_i};
        sh_over = (b_i >= SH_LIMIT);
        sh_amt  = b_i[SHW-1:0];
        cin_add = sum_w[MSB] ^ a_i[MSB] ^ b_i[MSB];
        cin_sub = diff_w[MSB] ^ a_i[MSB] ^ ~b_i[MSB];

        lane_d = '0;
        unique case (fn_i)
            FN_ADD: begin
                lane_d.lo   = sum_w[LW-1:0];
                lane_d.fl.c = sum_w[LW];
                lane_d.fl.v = cin_add ^ sum_w[LW];
            end
            FN_SUB: begin
                lane_d.lo   = diff_w[LW-1:0];
                lane_d.fl.c = diff_w[LW];
                lane_d.fl.v = cin_sub ^ ~diff_w[LW];
            end
            FN_AND: lane_d.lo = a_i & b_i;
            FN_OR:  lane_d.lo = a_i | b_i;
            FN_XOR: lane_d.lo = a_i ^ b_i;
            FN_SHL: lane_d.lo = sh_over ? '0 : (a_i << sh_amt);
            FN_LSR: lane_d.lo = sh_over ? '0 : (a_i >> sh_amt);
            FN_ASR: lane_d.lo = sh_over ? {LW{a_i[MSB]}}
                                        : $unsigned($signed(a_i) >>> sh_amt);
            FN_DIV: begin
                lane_d.dz = (b_i == '0);
                if (b_i != '0) begin
                    lane_d.lo = a_i / b_i;
                    lane_d.hi = a_i % b_i;
                end
            end
            FN_MUL: begin
                lane_d.lo = prod_w[LW-1:0];
                lane_d.hi = prod_w[2*LW-1:LW];
            end
            default: lane_d = '0;
        endcase
        lane_d.fl.z = (lane_d.lo == '0);
        lane_d.fl.s = lane_d.lo[MSB];
    end

    assign lo_o    = lane_d.lo;
    assign hi_o    = lane_d.hi;
    assign flags_o = lane_d.fl;
    assign dz_o    = lane_d.dz;

    always_comb begin
        if (fn_i == FN_SUB) begin
            AST_SUB_BORROW: assert (lane_d.fl.c == (a_i < b_i)); // R2
        end
        if (fn_i == FN_ADD) begin
            AST_ADD_OVERFLOW: assert (lane_d.fl.v ==
                ((a_i[MSB] == b_i[MSB]) && (lane_d.lo[MSB] != a_i[MSB]))); // R3
        end
        if ((fn_i == FN_SHL || fn_i == FN_LSR) && (b_i >= SH_LIMIT)) begin
            AST_SHIFT_SATURATE: assert (lane_d.lo == '0); // R5
        end
        if (fn_i == FN_DIV && b_i != '0) begin
            AST_DIV_IDENTITY: assert ((({{LW{1'b0}}, lane_d.lo} * {{LW{1'b0}}, b_i})
                + {{LW{1'b0}}, lane_d.hi}) == {{LW{1'b0}}, a_i}); // R6
            AST_REM_BELOW_DIVISOR: assert (lane_d.hi < b_i); // R6
        end
        if (fn_i != FN_DIV) begin
            AST_FAULT_ONLY_DIV: assert (!lane_d.dz); // R7
        end
    end

endmodule

// File: rtl/branch_eval.sv
module branch_eval
    import alu_pkg::*;
(
    input  logic [7:0] cond_i,
    input  flags_t     flags_i,
    output logic       taken_o
);

    logic sv_differ;
    logic taken_d;

    always_comb begin
        sv_differ = flags_i.s ^ flags_i.v;
        unique case (cond_i)
            BR_ZS:   taken_d = flags_i.z;
            BR_ZC:   taken_d = !flags_i.z;
            BR_VS:   taken_d = flags_i.v;
            BR_VC:   taken_d = !flags_i.v;
            BR_CS:   taken_d = flags_i.c;
            BR_CC:   taken_d = !flags_i.c;
            BR_SLT:  taken_d = sv_differ;
            BR_SGE:  taken_d = !sv_differ;
            BR_SLE:  taken_d = sv_differ || flags_i.z;
            BR_SGT:  taken_d = !sv_differ && !flags_i.z;
            BR_UGT:  taken_d = !flags_i.c && !flags_i.z;
            BR_ULE:  taken_d = flags_i.c || flags_i.z;
            default: taken_d = 1'b0;
        endcase
    end

    assign taken_o = taken_d;

    always_comb begin
        if (cond_i == BR_SLE && flags_i.z) begin
            AST_SLE_ON_ZERO: assert (taken_o); // R11
        end
        if (cond_i == BR_SGT && flags_i.z) begin
            AST_SGT_NOT_ZERO: assert (!taken_o); // R10
        end
    end

endmodule

// File: rtl/alu_branch_unit.sv
module alu_branch_unit
    import alu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [7:0]        op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [DATA_W-1:0] res_lo_o,
    output logic [DATA_W-1:0] res_hi_o,
    output logic [3:0]        flags_o,
    output logic              div_fault_o,
    input  logic [7:0]        br_op_i,
    input  logic [3:0]        br_flags_i,
    output logic              br_taken_o
);

    localparam int BYTE_W  = DATA_W / 2;
    localparam int N_LANES = 2;

    typedef struct packed {
        logic [DATA_W-1:0] lo;
        logic [DATA_W-1:0] hi;
        flags_t            fl;
        logic              dz;
    } unit_out_t;

    logic [4:0]        op_idx;
    logic              op_known;
    logic              op_wide;
    alu_fn_e           op_fn;
    logic [DATA_W-1:0] lane_lo [N_LANES];
    logic [DATA_W-1:0] lane_hi [N_LANES];
    flags_t            lane_fl [N_LANES];
    logic              lane_dz [N_LANES];
    unit_out_t         unit_d;

    assign op_idx   = 5'(op_i - OP_ALU_FIRST);
    assign op_known = (op_i >= OP_ALU_FIRST) && (op_i <= OP_ALU_LAST);
    assign op_wide  = op_idx[0];
    assign op_fn    = alu_fn_e'(op_idx[4:1]);

    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        localparam int GW = (g == 0) ? BYTE_W : DATA_W;
        logic [GW-1:0] lo_w;
        logic [GW-1:0] hi_w;
        flags_t        fl_w;
        logic          dz_w;

        alu_lane #(.LW(GW)) u_lane (
            .fn_i    (op_fn),
            .a_i     (a_i[GW-1:0]),
            .b_i     (b_i[GW-1:0]),
            .lo_o    (lo_w),
            .hi_o    (hi_w),
            .flags_o (fl_w),
            .dz_o    (dz_w)
        );

        assign lane_lo[g] = DATA_W'(lo_w);
        assign lane_hi[g] = DATA_W'(hi_w);
        assign lane_fl[g] = fl_w;
        assign lane_dz[g] = dz_w;
    end

    always_comb begin
        unit_d = '0;
        if (op_known) begin
            unit_d.lo = lane_lo[op_wide];
            unit_d.hi = lane_hi[op_wide];
            unit_d.fl = lane_fl[op_wide];
            unit_d.dz = lane_dz[op_wide];
        end
    end

    assign res_lo_o    = unit_d.lo;
    assign res_hi_o    = unit_d.hi;
    assign flags_o     = unit_d.fl;
    assign div_fault_o = unit_d.dz;

    branch_eval u_branch (
        .cond_i  (br_op_i),
        .flags_i (flags_t'(br_flags_i)),
        .taken_o (br_taken_o)
    );

    always_comb begin
        if (op_known && !op_wide) begin
            AST_BYTE_ZERO_EXTEND: assert (res_lo_o[DATA_W-1:BYTE_W] == '0
                && res_hi_o[DATA_W-1:BYTE_W] == '0); // R1
        end
        if (!op_known) begin
            AST_UNKNOWN_QUIET: assert (res_lo_o == '0 && res_hi_o == '0
                && flags_o == '0 && !div_fault_o); // R1
        end
    end

endmodule

// File: tb/tb_alu_branch_unit.sv
module tb_alu_branch_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  op_i = 8'h00;
    logic [15:0] a_i = 16'h0;
    logic [15:0] b_i = 16'h0;
    logic [15:0] res_lo_o;
    logic [15:0] res_hi_o;
    logic [3:0]  flags_o;
    logic        div_fault_o;
    logic [7:0]  br_op_i = 8'h00;
    logic [3:0]  br_flags_i = 4'h0;
    logic        br_taken_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    localparam logic [3:0] FZ = 4'h1, FS = 4'h2, FC = 4'h4, FV = 4'h8;

    always #10 clk = ~clk;

    alu_branch_unit dut (
        .op_i(op_i), .a_i(a_i), .b_i(b_i),
        .res_lo_o(res_lo_o), .res_hi_o(res_hi_o), .flags_o(flags_o),
        .div_fault_o(div_fault_o),
        .br_op_i(br_op_i), .br_flags_i(br_flags_i), .br_taken_o(br_taken_o)
    );

    task automatic drive(input logic [7:0] op, input logic [15:0] a, input logic [15:0] b);
        @(posedge clk);
        op_i = op; a_i = a; b_i = b;
        @(negedge clk);
    endtask

    task automatic expect_alu(input string req, input logic [15:0] lo,
                              input logic [15:0] hi, input logic [3:0] fl);
        checks++;
        if (res_lo_o !== lo || res_hi_o !== hi || flags_o !== fl) begin
            failures++;
            $display("FAIL %s op=%h: actual lo=%h hi=%h fl=%h expected lo=%h hi=%h fl=%h",
                     req, op_i, res_lo_o, res_hi_o, flags_o, lo, hi, fl);
        end
    endtask

    task automatic expect_fault(input string req, input logic exp);
        checks++;
        if (div_fault_o !== exp) begin
            failures++;
            $display("FAIL %s op=%h: actual fault=%b expected fault=%b", req, op_i, div_fault_o, exp);
        end
    endtask

    task automatic test_reset_state;
        drive(8'h00, 16'h1234, 16'h5678);
        expect_alu("R1 idle", 16'h0, 16'h0, 4'h0);
        expect_fault("R1 idle", 1'b0);
        checks++;
        if (br_taken_o !== 1'b0) begin
            failures++;
            $display("FAIL R10 idle branch: actual %b expected 0", br_taken_o);
        end
        drive(8'h55, 16'h0001, 16'h0000);
        expect_alu("R1 above range", 16'h0, 16'h0, 4'h0);
        expect_fault("R1 above range", 1'b0);
        drive(8'h40, 16'h0001, 16'h0001);
        expect_alu("R1 below range", 16'h0, 16'h0, 4'h0);
    endtask

    task automatic test_add_sub;
        drive(8'h41, 16'h12F0, 16'h3420);
        expect_alu("R2 byte add carry, R1 upper bytes ignored", 16'h0010, 16'h0, FC);
        drive(8'h42, 16'h7FFF, 16'h0001);
        expect_alu("R3 wide add overflow", 16'h8000, 16'h0, FV | FS);
        drive(8'h42, 16'hFFFF, 16'h0001);
        expect_alu("R2 wide add wrap", 16'h0000, 16'h0, FZ | FC);
        drive(8'h43, 16'h0005, 16'h0007);
        expect_alu("R2 byte sub borrow", 16'h00FE, 16'h0, FC | FS);
        drive(8'h44, 16'h8000, 16'h0001);
        expect_alu("R3 wide sub overflow", 16'h7FFF, 16'h0, FV);
        drive(8'h44, 16'h1234, 16'h1234);
        expect_alu("R9 wide sub zero", 16'h0000, 16'h0, FZ);
        drive(8'h41, 16'h0080, 16'h0080);
        expect_alu("R3 byte add overflow", 16'h0000, 16'h0, FZ | FC | FV);
    endtask

    task automatic test_logic;
        drive(8'h46, 16'hF0F0, 16'hFF00);
        expect_alu("R4 wide and", 16'hF000, 16'h0, FS);
        drive(8'h47, 16'h0F0F, 16'h00F0);
        expect_alu("R4 byte or", 16'h00FF, 16'h0, FS);
        drive(8'h4A, 16'h5555, 16'h5555);
        expect_alu("R4 wide xor zero", 16'h0000, 16'h0, FZ);
    endtask

    task automatic test_shifts;
        drive(8'h4B, 16'h0081, 16'h0001);
        expect_alu("R5 byte shl drops top bit", 16'h0002, 16'h0, 4'h0);
        drive(8'h4C, 16'h0001, 16'h0010);
        expect_alu("R5 wide shl by width", 16'h0000, 16'h0, FZ);
        drive(8'h4C, 16'h0001, 16'h000F);
        expect_alu("R5 wide shl by width-1", 16'h8000, 16'h0, FS);
        drive(8'h4D, 16'h0080, 16'h0003);
        expect_alu("R5 byte asr", 16'h00F0, 16'h0, FS);
        drive(8'h4E, 16'h8000, 16'h0020);
        expect_alu("R5 wide asr beyond width", 16'hFFFF, 16'h0, FS);
        drive(8'h4E, 16'h4000, 16'h0001);
        expect_alu("R5 wide asr positive", 16'h2000, 16'h0, 4'h0);
        drive(8'h50, 16'h8000, 16'h000F);
        expect_alu("R5 wide lsr", 16'h0001, 16'h0, 4'h0);
        drive(8'h4F, 16'h0080, 16'h0108);
        expect_alu("R5 byte lsr by width", 16'h0000, 16'h0, FZ);
        drive(8'h4F, 16'h0080, 16'h0107);
        expect_alu("R5 byte lsr upper amount byte ignored", 16'h0001, 16'h0, 4'h0);
    endtask

    task automatic test_divide;
        drive(8'h51, 16'h0064, 16'h0007);
        expect_alu("R6 byte div", 16'h000E, 16'h0002, 4'h0);
        expect_fault("R7 byte div nonzero", 1'b0);
        drive(8'h52, 16'hFFFF, 16'h0010);
        expect_alu("R6 wide div", 16'h0FFF, 16'h000F, 4'h0);
        drive(8'h52, 16'h0003, 16'h0009);
        expect_alu("R6 wide div small dividend", 16'h0000, 16'h0003, FZ);
        drive(8'h51, 16'h0005, 16'h0100);
        expect_fault("R7 byte divisor zero in low byte", 1'b1);
        drive(8'h52, 16'h0005, 16'h0000);
        expect_fault("R7 wide divisor zero", 1'b1);
        drive(8'h52, 16'h0005, 16'h0100);
        expect_fault("R7 wide divisor nonzero", 1'b0);
        drive(8'h42, 16'h0005, 16'h0000);
        expect_fault("R7 add with zero operand", 1'b0);
    endtask

    task automatic test_multiply;
        drive(8'h53, 16'h12FF, 16'h34FF);
        expect_alu("R8 byte mul", 16'h0001, 16'h00FE, 4'h0);
        drive(8'h54, 16'h1234, 16'h0100);
        expect_alu("R8 wide mul", 16'h3400, 16'h0012, 4'h0);
        drive(8'h54, 16'h8000, 16'h0002);
        expect_alu("R9 wide mul low zero", 16'h0000, 16'h0001, FZ);
        drive(8'h54, 16'hFFFF, 16'hFFFF);
        expect_alu("R8 wide mul max", 16'h0001, 16'hFFFE, 4'h0);
    endtask

    function automatic logic branch_expect(input logic [7:0] c, input logic [3:0] f);
        logic z, s, cy, v;
        z = f[0]; s = f[1]; cy = f[2]; v = f[3];
        case (c)
            8'h2F: return z;
            8'h34: return ~z;
            8'h35: return v;
            8'h36: return ~v;
            8'h37: return cy;
            8'h38: return ~cy;
            8'h30: return s != v;
            8'h33: return s == v;
            8'h31: return (s != v) | z;
            8'h32: return (s == v) & ~z;
            8'h39: return ~cy & ~z;
            8'h3A: return cy | z;
            default: return 1'b0;
        endcase
    endfunction

    task automatic test_branches;
        for (int c = 8'h2E; c <= 8'h3B; c++) begin
            for (int f = 0; f < 16; f++) begin
                @(posedge clk);
                br_op_i = 8'(c); br_flags_i = 4'(f);
                @(negedge clk);
                checks++;
                if (br_taken_o !== branch_expect(8'(c), 4'(f))) begin
                    failures++;
                    $display("FAIL %s cond=%h flags=%h: actual %b expected %b",
                             (c == 8'h31) ? "R11" : "R10", c, f, br_taken_o,
                             branch_expect(8'(c), 4'(f)));
                end
            end
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        test_reset_state();
        test_add_sub();
        test_logic();
        test_shifts();
        test_divide();
        test_multiply();
        test_branches();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule